// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host-side master for a sampling analog-to-digital converter with a three-wire serial link: chip select, serial clock and one data line. A one-cycle start request in idle lowers chip select. The block then runs a serial clock divided down from the system clock. Chip select falling begins both the conversion and the transfer in the converter. The first clock periods belong to the converter's sampling interval and their data is discarded. The next period must carry a null bit that reads low. After it come the result bits, most significant first. The converter changes its data line on the falling serial-clock edge, so every bit is captured on the rising edge.

The block has two modes. In standard mode the frame ends after the least significant bit. In extended mode the frame runs on while the converter repeats the word least significant bit first, B1 up to B15. Each repeated bit is compared against the word captured first. Once the last period of a frame has ended, chip select goes high and a valid strobe presents the word and an error flag. Chip select then stays high for a programmable hold time before a new frame can start. The converter itself needs chip select to toggle before it starts a new conversion.

The controller is a three-state machine: IDLE, CONVERT and HOLD. The transitions are:

- IDLE to CONVERT when a start is accepted.
- CONVERT to HOLD on the falling serial-clock edge that ends the last period.
- HOLD to IDLE when the hold count expires.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, valid is 0, result is 0 and error is 0.
- R2: A start seen in IDLE makes cs_n 0 from the next cycle. sclk is 0 whenever cs_n is 1. Each serial-clock period is HALF_DIV cycles low followed by HALF_DIV cycles high, beginning low as soon as cs_n falls.
- R3: A standard frame has exactly SAMPLE_CLKS+1+DATA_W serial-clock periods (22 with the defaults). An extended frame has SAMPLE_CLKS+2*DATA_W periods (37). cs_n rises in the cycle after the last falling sclk edge.
- R4: sdata is sampled on rising sclk edges, and rises are numbered from 1 within the frame. Rises 1 to SAMPLE_CLKS are ignored. Rise SAMPLE_CLKS+1 is the null bit. The next DATA_W rises give result bits B15 down to B0. The result is straight binary, so 0x0000, 0x8000, 0x7FFF and 0xFFFF are passed through unchanged.
- R5: If the null bit samples as 1, error is 1 for that frame.
- R6: In extended mode, the rises after B0 carry B1 up to B15. Any one of them that differs from the word captured first sets error. In standard mode the data after B0 has no effect on error or result.
- R7: valid is 1 for exactly one cycle, the first cycle in which cs_n is 1 after a frame. result and error take the new frame's values in that same cycle and hold them until the next valid.
- R8: cs_n stays 1 for at least CS_HIGH cycles between frames. A start while cs_n is 0 or during the hold time is ignored, and no extra frame results from it.
- R9: ext_mode is taken only in the cycle a start is accepted. Changing it during a frame alters neither the frame length nor the error result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one conversion frame |
| ext_mode | input | 1 | Select extended frame with repeat check |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock to the converter |
| result | output | DATA_W | Last captured conversion word |
| valid | output | 1 | One-cycle strobe with a new result |
| error | output | 1 | Null bit high or repeat mismatch in last frame |

## Verification
A behavioural converter model in the bench drives the data line from the falling serial-clock edges. The bench compares the words zero, midscale, midscale minus one, full scale and a mixed pattern, and each of these would expose a bit-order slip or a dropped bit in a different way. Frames with a high null bit and with a single flipped repeat bit, in both modes, show whether the error flag depends on the right mode. Start pulses issued mid-frame and during the hold time, and an ext_mode change mid-frame, show whether the reference model's frame timing and the design's chip-select and clock waveforms stay in step on every cycle.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_HOLD
    } rd_state_t;
endpackage

// File: rtl/adc_rd_clkgen.sv
module adc_rd_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_p,
    output logic fall_p
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap   = run && (cnt == CW'(HALF_DIV - 1));
    assign rise_p = wrap && !sclk;
    assign fall_p = wrap && sclk;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
    parameter int DATA_W      = 16,
    parameter int SAMPLE_CLKS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rise_p,
    input  logic              sdata,
    input  logic              ext,
    input  logic              finish,
    output logic [DATA_W-1:0] result,
    output logic              valid,
    output logic              error
);
    localparam int NULL_IDX = SAMPLE_CLKS + 1;
    localparam int FIRST    = SAMPLE_CLKS + 2;
    localparam int LAST     = SAMPLE_CLKS + 1 + DATA_W;
    localparam int REP_LAST = SAMPLE_CLKS + 2 * DATA_W;
    localparam int IW       = $clog2(REP_LAST + 2);
    localparam int BW       = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [IW-1:0]     ridx;
    logic [DATA_W-1:0] shreg;
    logic              null_bad;
    logic              rep_bad;
    logic              in_word;
    logic              in_rep;
    logic              rep_bit;

    assign in_word = (ridx >= IW'(FIRST)) && (ridx <= IW'(LAST));
    assign in_rep  = ext && (ridx > IW'(LAST)) && (ridx <= IW'(REP_LAST));

    always_comb begin
        rep_bit = shreg[BW'(ridx - IW'(LAST))];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ridx     <= IW'(1);
            shreg    <= '0;
            null_bad <= 1'b0;
            rep_bad  <= 1'b0;
        end else if (clear) begin
            ridx     <= IW'(1);
            null_bad <= 1'b0;
            rep_bad  <= 1'b0;
        end else if (rise_p) begin
            ridx <= ridx + 1'b1;
            if (ridx == IW'(NULL_IDX)) begin
                null_bad <= sdata;
            end
            if (in_word) begin
                shreg <= {shreg[DATA_W-2:0], sdata};
            end
            if (in_rep && (sdata != rep_bit)) begin
                rep_bad <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            error  <= 1'b0;
            valid  <= 1'b0;
        end else begin
            valid <= finish;
            if (finish) begin
                result <= shreg;
                error  <= null_bad | rep_bad;
            end
        end
    end
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
    import adc_rd_pkg::*;
#(
    parameter int HALF_DIV    = 2,
    parameter int CS_HIGH     = 4,
    parameter int DATA_W      = 16,
    parameter int SAMPLE_CLKS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ext_mode,
    input  logic              sdata,
    output logic              cs_n,
    output logic              sclk,
    output logic [DATA_W-1:0] result,
    output logic              valid,
    output logic              error
);
    localparam int NPER_STD = SAMPLE_CLKS + 1 + DATA_W;
    localparam int NPER_EXT = SAMPLE_CLKS + 2 * DATA_W;
    localparam int FW       = $clog2(NPER_EXT + 1);
    localparam int HW       = $clog2(CS_HIGH + 1);

    rd_state_t     state, nstate;
    logic [FW-1:0] fcnt;
    logic [HW-1:0] hcnt;
    logic          ext_q;
    logic          run;
    logic          rise_p, fall_p;
    logic          accept, finish, last_fall, hold_done;

    assign accept    = (state == ST_IDLE) && start;
    assign last_fall = (fcnt == (ext_q ? FW'(NPER_EXT - 1) : FW'(NPER_STD - 1)));
    assign finish    = (state == ST_CONVERT) && fall_p && last_fall;
    assign hold_done = (hcnt == HW'(CS_HIGH - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:    if (start)     nstate = ST_CONVERT;
            ST_CONVERT: if (finish)    nstate = ST_HOLD;
            ST_HOLD:    if (hold_done) nstate = ST_IDLE;
            default:                   nstate = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        cs_n = 1'b1;
        run  = 1'b0;
        unique case (state)
            ST_CONVERT: begin
                cs_n = 1'b0;
                run  = 1'b1;
            end
            ST_IDLE, ST_HOLD: begin
                cs_n = 1'b1;
                run  = 1'b0;
            end
            default: begin
                cs_n = 1'b1;
                run  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt  <= '0;
            hcnt  <= '0;
            ext_q <= 1'b0;
        end else begin
            if (accept) begin
                fcnt  <= '0;
                ext_q <= ext_mode;
            end else if ((state == ST_CONVERT) && fall_p) begin
                fcnt <= fcnt + 1'b1;
            end
            if (state != ST_HOLD) hcnt <= '0;
            else                  hcnt <= hcnt + 1'b1;
        end
    end

    adc_rd_clkgen #(
        .HALF_DIV(HALF_DIV)
    ) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sclk  (sclk),
        .rise_p(rise_p),
        .fall_p(fall_p)
    );

    adc_rd_capture #(
        .DATA_W     (DATA_W),
        .SAMPLE_CLKS(SAMPLE_CLKS)
    ) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .rise_p(rise_p),
        .sdata (sdata),
        .ext   (ext_q),
        .finish(finish),
        .result(result),
        .valid (valid),
        .error (error)
    );
endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk #(
    parameter int CS_HIGH     = 4,
    parameter int DATA_W      = 16,
    parameter int SAMPLE_CLKS = 5
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic valid
);
    localparam int NSTD = SAMPLE_CLKS + 1 + DATA_W;
    localparam int NEXT = SAMPLE_CLKS + 2 * DATA_W;
    localparam int RW   = $clog2(NEXT + 2);
    localparam int HW   = $clog2(CS_HIGH + 2);

    logic          sclk_q;
    logic [RW-1:0] rcnt;
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            rcnt   <= '0;
            hi_cnt <= HW'(CS_HIGH);
        end else begin
            sclk_q <= sclk;
            if (cs_n)                rcnt <= '0;
            else if (sclk && !sclk_q) rcnt <= rcnt + 1'b1;
            if (!cs_n)                     hi_cnt <= '0;
            else if (hi_cnt < HW'(CS_HIGH)) hi_cnt <= hi_cnt + 1'b1;
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R2

    AST_FRAME_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> ((rcnt == RW'(NSTD)) || (rcnt == RW'(NEXT)))); // R3

    AST_VALID_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (cs_n && !$past(cs_n))); // R7

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R7

    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= HW'(CS_HIGH))); // R8
endmodule

bind adc_serial_reader adc_serial_reader_chk #(
    .CS_HIGH    (CS_HIGH),
    .DATA_W     (DATA_W),
    .SAMPLE_CLKS(SAMPLE_CLKS)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .cs_n (cs_n),
    .sclk (sclk),
    .valid(valid)
);

// File: tb/adc_serial_reader_tb.sv
module adc_serial_reader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;
    localparam int CSH  = 4;
    localparam int W    = 16;
    localparam int SMP  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ext_mode = 1'b0;
    logic sdata;
    logic cs_n, sclk, valid, error;
    logic [W-1:0] result;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_serial_reader #(
        .HALF_DIV(HALF), .CS_HIGH(CSH), .DATA_W(W), .SAMPLE_CLKS(SMP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ext_mode(ext_mode),
        .sdata(sdata), .cs_n(cs_n), .sclk(sclk), .result(result),
        .valid(valid), .error(error)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // converter model
    logic [W-1:0] dev_word = '0;
    bit dev_null_bad = 0;
    bit dev_rep_bad = 0;
    int dev_rep_pos = 1;
    int fcount = 0;
    int nrise = 0;
    int nframes = 0;

    function automatic logic dev_bit(input int k);
        if (k < SMP) return k[0];
        if (k == SMP) return dev_null_bad;
        if (k <= SMP + W) return dev_word[SMP + W - k];
        if (k < SMP + 2 * W) return dev_word[k - SMP - W] ^
                                    (dev_rep_bad && (k - SMP - W == dev_rep_pos));
        return 1'b1;
    endfunction

    initial sdata = 1'b1;
    always @(negedge sclk) if (cs_n === 1'b0) begin
        fcount = fcount + 1;
        sdata = dev_bit(fcount);
    end
    always @(posedge cs_n) begin
        fcount = 0;
        sdata = 1'b1;
    end
    always @(negedge cs_n) begin
        nrise = 0;
        nframes = nframes + 1;
    end
    always @(posedge sclk) if (cs_n === 1'b0) nrise = nrise + 1;

    // reference model, compared every cycle
    int m_state = 0;
    int m_c = 0, m_h = 0, m_n = 0;
    bit m_vld = 0, m_ext = 0, m_err = 0;
    logic [W-1:0] m_res = '0;

    always @(negedge clk) if (rst_n) begin
        check(cs_n == (m_state != 1), "R2 cs_n", 32'(cs_n), 32'(m_state != 1));
        check(sclk == ((m_state == 1) ? ((m_c / HALF) % 2 == 1) : 1'b0),
              "R3 sclk", 32'(sclk), 32'((m_state == 1) && ((m_c / HALF) % 2 == 1)));
        check(valid == m_vld, "R7 valid", 32'(valid), 32'(m_vld));
        check(result == m_res, "R7 result held", 32'(result), 32'(m_res));
        check(error == m_err, "R7 error held", 32'(error), 32'(m_err));
        if (m_vld)
            check(nrise == m_n, "R3 periods", 32'(nrise), 32'(m_n));
        m_vld = 0;
        case (m_state)
            0: if (start) begin
                m_state = 1; m_c = 0; m_ext = ext_mode;
                m_n = ext_mode ? SMP + 2 * W : SMP + 1 + W;
            end
            1: if (m_c == m_n * 2 * HALF - 1) begin
                m_state = 2; m_h = 0; m_vld = 1;
                m_res = dev_word;
                m_err = dev_null_bad || (m_ext && dev_rep_bad);
            end else m_c++;
            default: if (m_h == CSH - 1) m_state = 0; else m_h++;
        endcase
    end

    task automatic pulse_start(input bit ext);
        @(posedge clk); #1; start = 1'b1; ext_mode = ext;
        @(posedge clk); #1; start = 1'b0;
    endtask

    task automatic wait_valid();
        do @(negedge clk); while (valid !== 1'b1);
    endtask

    task automatic frame(input logic [W-1:0] w, input bit ext, input bit nb,
                         input bit rb, input int rp, input string tag);
        dev_word = w; dev_null_bad = nb; dev_rep_bad = rb; dev_rep_pos = rp;
        pulse_start(ext);
        wait_valid();
        check(result == w, tag, 32'(result), 32'(w));
        check(error == (nb || (ext && rb)), tag, 32'(error), 32'(nb || (ext && rb)));
        repeat (CSH + 2) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(cs_n && !sclk && !valid && result == 0 && !error, "R1 reset",
              {27'd0, cs_n, sclk, valid, error, |result}, 32'h10);
        frame(16'h0000, 0, 0, 0, 1, "R4 zero");
        frame(16'hFFFF, 0, 0, 0, 1, "R4 full scale");
        frame(16'h8000, 0, 0, 0, 1, "R4 midscale");
        frame(16'h7FFF, 0, 0, 0, 1, "R4 midscale-1");
        frame(16'hA5C3, 0, 0, 0, 1, "R4 mixed");
        frame(16'h1234, 0, 1, 0, 1, "R5 null high");
        frame(16'h1234, 0, 0, 0, 1, "R5 null low clears");
        frame(16'hC0DE, 1, 0, 0, 1, "R6 ext match");
        frame(16'hC0DE, 1, 0, 1, 7, "R6 ext mismatch");
        frame(16'h8001, 1, 0, 1, 15, "R6 ext mismatch msb");
        frame(16'hBEEF, 0, 0, 1, 3, "R6 std ignores repeat");
        // R9: ext_mode changed mid-frame, R8: starts while busy
        dev_word = 16'h5A5A; dev_null_bad = 0; dev_rep_bad = 1; dev_rep_pos = 2;
        begin
            int f0;
            f0 = nframes;
            pulse_start(0);
            repeat (20) @(posedge clk);
            #1 ext_mode = 1'b1; start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
            wait_valid();
            check(error == 1'b0, "R9 ext latched", 32'(error), 32'd0);
            check(result == 16'h5A5A, "R9 result", 32'(result), 32'h5A5A);
            @(posedge clk); #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
            repeat (CSH + 6) @(posedge clk);
            check(nframes == f0 + 1, "R8 busy start ignored", 32'(nframes),
                  32'(f0 + 1));
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R3 act=hung exp=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule